// File: doc/BRIEF.md
# UART Baud Tick Generator

This block produces the timing pulses that pace a UART's serial shifters. Software programs a 16-bit rate value, one byte at a time, through a small register write port. A control register selects how that value is used. In integer mode, the value is a division count. In fractional mode, it is a phase increment that is summed into an accumulator.

The generator emits a one-clock sample tick at the oversampling rate. From that sample tick it derives a one-clock bit tick at the serial bit rate. One control bit lowers the oversampling ratio from 16 to 8, which doubles the bit rate for the same programmed value.

When the enable bit is clear, every counter and the accumulator are held at zero. Each new enable therefore starts from a known phase. Shifters, FIFOs and the bus interface sit outside this block.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is active, or while the enable bit (control bit 0) is clear, neither tick is ever high. Counters and the accumulator are cleared, so each enable restarts the tick sequence from the same phase.
- R2: Register writes decode the address as follows: 0 is the low rate byte, 1 is the high rate byte, 2 is control, and 3 is ignored. The control bits are enable (bit 0), fractional mode (bit 1) and 8x oversampling (bit 2). A write to address 3 leaves the tick pattern unchanged.
- R3: In integer mode with rate value D, suppose the enable write is captured at clock edge k. The sample tick is then high for exactly the one cycle that follows each edge k + m·(D+1), for every m ≥ 1. The resulting period is D+1 clocks.
- R4: In integer mode with D = 0, the sample tick is high in every cycle, starting with the cycle after edge k+1.
- R5: In fractional mode with increment N, count the enabled cycles j = 0, 1, … after edge k. A raw tick occurs in cycle j when floor((j+1)·N / 65536) differs from floor(j·N / 65536), i.e. when the 16-bit accumulator carries out. The sample tick then shows that raw tick in the cycle that follows.
- R6: In fractional mode with an increment of 0, no sample tick is produced.
- R7: With 16x oversampling (control bit 2 clear), the bit tick is high together with every 16th sample tick, counted from the enable.
- R8: With 8x oversampling (control bit 2 set), the bit tick is high together with every 8th sample tick, counted from the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 low byte, 1 high byte, 2 control) |
| wr_data | input | 8 | Register write data |
| sample_tick | output | 1 | One-clock oversampling tick |
| bit_tick | output | 1 | One-clock bit-rate tick |

## Verification
The bench builds the block with its default parameters: a 16-bit rate value and oversampling ratios of 16 and 8. Small programmed values such as 0 and 2 give many sample ticks and several bit ticks within a few hundred clocks. A value of 0x0105 puts a nonzero byte in the high register and so exercises the byte split. Fractional increments of 0x8000, 0x5555, 0xFFFF and 0 cover an exact carry period, an uneven carry pattern, near-continuous carries across the full 16-bit width, and the case where the accumulator never carries.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Control register layout: bit 0 enable, bit 1 fractional mode, bit 2 8x oversampling
  typedef struct packed {
    logic ovs8;
    logic frac;
    logic enable;
  } baud_ctrl_t;

  localparam int CTRL_BITS = 3;

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_gen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [DIV_W-1:0]  divisor_o,
  output baud_ctrl_t        ctrl_o
);

  localparam int NBYTES = DIV_W / 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES);

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_byte
      logic [7:0] byte_q;
      logic       byte_we;

      always_comb begin
        byte_we = wr_en && (wr_addr == ADDR_W'(g));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_q <= '0;
        end else if (byte_we) begin
          byte_q <= wr_data;
        end
      end

      assign divisor_o[g*8 +: 8] = byte_q;
    end
  endgenerate

  logic       ctrl_we;
  baud_ctrl_t ctrl_q;

  always_comb begin
    ctrl_we = wr_en && (wr_addr == CTRL_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= baud_ctrl_t'(wr_data[CTRL_BITS-1:0]);
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/baud_int_div.sv
module baud_int_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             wrap;

  always_comb begin
    wrap   = active_i && (cnt_q >= divisor_i);
    tick_o = wrap;
    if (!active_i || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: with a nonzero divisor, two raw ticks never fall in adjacent cycles
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && divisor_i != '0) |=> (!tick_o || divisor_i == '0));

  // R4: a zero divisor ticks on every active cycle
  a_r4_zero_div_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && divisor_i == '0) |-> tick_o);

endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic [DIV_W-1:0] incr_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] acc_q;
  logic [DIV_W-1:0] acc_d;
  logic [DIV_W:0]   sum;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, incr_i};
    tick_o = active_i && sum[DIV_W];
    acc_d  = active_i ? sum[DIV_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  // R6: a zero increment can never carry out of the accumulator
  a_r6_zero_incr_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (incr_i == '0) |-> !tick_o);

endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int OVS_HI = 16,
  parameter int OVS_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic ovs_lo_i,
  input  logic samp_i,
  output logic bit_o
);

  localparam int CNT_W = $clog2(OVS_HI);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(OVS_HI - 1);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(OVS_LO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last;
  logic             wrap;

  always_comb begin
    last  = ovs_lo_i ? LAST_LO : LAST_HI;
    wrap  = samp_i && (cnt_q >= last);
    bit_o = wrap;
    if (!active_i || wrap) begin
      cnt_d = '0;
    end else if (samp_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R8: without a sample tick the sample count does not move
  a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !samp_i) |=> (!active_i || $stable(cnt_q)));

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_gen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 2,
  parameter int OVS_HI = 16,
  parameter int OVS_LO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              sample_tick,
  output logic              bit_tick
);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  logic [DIV_W-1:0] rate;
  baud_ctrl_t       ctrl;

  baud_cfg_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .divisor_o (rate),
    .ctrl_o    (ctrl)
  );

  logic int_active;
  logic frac_active;
  logic int_tick;
  logic frac_tick;
  logic samp_raw;
  logic bit_raw;

  always_comb begin
    int_active  = ctrl.enable && !ctrl.frac;
    frac_active = ctrl.enable && ctrl.frac;
    samp_raw    = int_tick || frac_tick;
  end

  baud_int_div #(.DIV_W(DIV_W)) u_int (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active_i  (int_active),
    .divisor_i (rate),
    .tick_o    (int_tick)
  );

  baud_frac_acc #(.DIV_W(DIV_W)) u_frac (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active_i (frac_active),
    .incr_i   (rate),
    .tick_o   (frac_tick)
  );

  baud_bit_div #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_bit (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active_i (ctrl.enable),
    .ovs_lo_i (ctrl.ovs8),
    .samp_i   (samp_raw),
    .bit_o    (bit_raw)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= samp_raw;
      bit_tick    <= bit_raw;
    end
  end

  // R7: a bit tick only ever coincides with a sample tick
  a_r7_bit_with_sample: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_tick |-> sample_tick);

  // R1: two disabled cycles in a row leave the sample output low
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl.enable && !$past(ctrl.enable)) |-> !sample_tick);

endmodule

// File: tb/uart_baud_gen_tb_top.sv
module uart_baud_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       sample_tick;
  logic       bit_tick;

  always #10 clk = ~clk;

  uart_baud_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
  );

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  string s_req = "R1";
  string b_req = "R1";
  int    exp_s[$];
  int    exp_b[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares each observed tick against the expected cycle queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (sample_tick) begin
        if (exp_s.size() == 0) check(1'b0, s_req, "unexpected sample tick at cycle", cyc, -1);
        else check(exp_s.pop_front() == cyc, s_req, "sample tick cycle", cyc, cyc);
      end else if (exp_s.size() > 0 && exp_s[0] <= cyc) begin
        check(1'b0, s_req, "missed sample tick, cycle", cyc, exp_s.pop_front());
      end
      if (bit_tick) begin
        if (exp_b.size() == 0) check(1'b0, b_req, "unexpected bit tick at cycle", cyc, -1);
        else check(exp_b.pop_front() == cyc, b_req, "bit tick cycle", cyc, cyc);
      end else if (exp_b.size() > 0 && exp_b[0] <= cyc) begin
        check(1'b0, b_req, "missed bit tick, cycle", cyc, exp_b.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Driver: programs a run, pushes the expected ticks, then disables
  task automatic run(input bit frac, input bit ovs8, input int val, input int win,
                     input bit poke3, input string sr, input string br,
                     output int nticks);
    int c;
    int n;
    int r;
    r = ovs8 ? 8 : 16;
    n = 0;
    wr(2'd0, val[7:0]);
    wr(2'd1, val[15:8]);
    s_req = sr;
    b_req = br;
    c = cyc;
    for (int j = 0; j < win; j++) begin
      bit tk;
      if (frac) tk = ((longint'(j + 1) * val) >>> 16) != ((longint'(j) * val) >>> 16);
      else      tk = ((j + 1) % (val + 1)) == 0;
      if (tk) begin
        n++;
        exp_s.push_back(c + 2 + j);
        if (n % r == 0) exp_b.push_back(c + 2 + j);
      end
    end
    wr(2'd2, {5'd0, ovs8, frac, 1'b1});
    if (poke3) begin
      repeat (win / 2) @(negedge clk);
      wr(2'd3, 8'hFF);
      repeat (win - 2 - win / 2) @(negedge clk);
    end else begin
      repeat (win - 1) @(negedge clk);
    end
    wr(2'd2, {5'd0, ovs8, frac, 1'b0});
    repeat (4) @(negedge clk);
    check(exp_s.size() == 0, sr, "sample ticks left pending", exp_s.size(), 0);
    check(exp_b.size() == 0, br, "bit ticks left pending", exp_b.size(), 0);
    exp_s.delete();
    exp_b.delete();
    nticks = n;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(sample_tick == 1'b0, "R1", "sample tick in reset", sample_tick, 0);
    check(bit_tick == 1'b0, "R1", "bit tick in reset", bit_tick, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    // R1: idle after reset, still disabled
    repeat (20) @(negedge clk);
    check(sample_tick == 1'b0 && bit_tick == 1'b0, "R1", "ticks while disabled", sample_tick, 0);
    // R3, R7: integer divisor 2, 16x
    run(1'b0, 1'b0, 2, 200, 1'b0, "R3", "R7", n);
    check(n == 66, "R3", "sample tick count", n, 66);
    // R1: second identical run restarts from the same phase
    run(1'b0, 1'b0, 2, 60, 1'b0, "R1", "R1", n);
    // R4, R8: divisor 0, 8x
    run(1'b0, 1'b1, 0, 40, 1'b0, "R4", "R8", n);
    check(n == 40, "R4", "tick every cycle count", n, 40);
    // R2: high byte in use
    run(1'b0, 1'b0, 16'h0105, 600, 1'b0, "R2", "R2", n);
    check(n == 2, "R2", "tick count with high byte", n, 2);
    // R2: write to unused address 3 mid-run is ignored
    run(1'b0, 1'b0, 4, 120, 1'b1, "R2", "R2", n);
    // R5, R7: fractional exact half
    run(1'b1, 1'b0, 16'h8000, 64, 1'b0, "R5", "R7", n);
    check(n == 32, "R5", "half-rate tick count", n, 32);
    // R5: uneven carry pattern
    run(1'b1, 1'b0, 16'h5555, 100, 1'b0, "R5", "R7", n);
    // R5, R8: full-width increment, 8x
    run(1'b1, 1'b1, 16'hFFFF, 40, 1'b0, "R5", "R8", n);
    // R6: zero increment
    run(1'b1, 1'b0, 0, 50, 1'b0, "R6", "R6", n);
    check(n == 0, "R6", "zero increment tick count", n, 0);
    repeat (10) @(negedge clk);
    check(sample_tick == 1'b0, "R1", "sample tick after final disable", sample_tick, 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule